// File: doc/BRIEF.md
# Double-Precision Placement Barrel Shifter

This block takes a 16-bit operand and drops it at any bit position of a 32-bit result field within one clock cycle. The landing spot is chosen by an 8-bit signed shift code together with a reference select that anchors a zero code either at the top half or at the bottom half of the field. A mode input decides whether vacated bits above the operand repeat its sign bit or are cleared. Vacated bits below the operand are always cleared.

The placed word is written into a 32-bit result register, either on its own or bitwise-ORed with what the register already holds. Two operations therefore build a 32-bit shift from 16-bit pieces: place the upper word against the high reference, then OR in the lower word placed against the low reference with the same code. The register can also be written and read as two 16-bit halves, so a 32-bit value can be loaded for later merging.

Top module: `placement_shifter`

## Requirements
- R1: While `rstN` is low, and after it rises until the first write, `resHi` and `resLo` are both zero.
- R2: With `refHigh` = 0 and `shiftCode` = 0, the operand lands at result bits 15:0.
- R3: With `refHigh` = 1 and `shiftCode` = 0, the operand lands at result bits 31:16 and bits 15:0 are zero.
- R4: `shiftCode` is an 8-bit two's-complement value; a positive code moves the operand that many bits toward bit 31 from its reference position, a negative code that many bits toward bit 0.
- R5: With `arithMode` = 1, every result bit above the operand equals operand bit 15; with `arithMode` = 0 those bits are zero; bits below the operand are zero in both modes.
- R6: When the effective placement (code plus 16 for the high reference) is 32 or more the placed word is all zero; when it is -16 or less the placed word is all fill bits (all ones for a negative operand in arithmetic mode, otherwise zero). Placements -16 through 32 give the 49 distinct results.
- R7: With `orMode` = 0 a shift writes the placed word alone into the result register.
- R8: With `orMode` = 1 a shift writes the placed word ORed with the current result register.
- R9: `loadLo` writes `loadData` into result bits 15:0 only, `loadHi` into bits 31:16 only; both may be asserted together; `resLo` and `resHi` show bits 15:0 and 31:16.
- R10: When `opValid` and a half load are asserted in the same cycle the shift is performed and the half load is ignored.
- R11: With `opValid`, `loadLo` and `loadHi` all low the result register holds its value whatever the other inputs do.
- R12: The result of a shift is visible at `resHi`/`resLo` right after the clock edge that samples `opValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Perform a shift this cycle |
| opData | input | 16 | Operand to place |
| shiftCode | input | 8 | Signed shift code |
| refHigh | input | 1 | 1: zero code places at bits 31:16; 0: at bits 15:0 |
| arithMode | input | 1 | 1: sign fill above the operand; 0: zero fill |
| orMode | input | 1 | 1: OR into result register; 0: overwrite |
| loadLo | input | 1 | Write `loadData` to result bits 15:0 |
| loadHi | input | 1 | Write `loadData` to result bits 31:16 |
| loadData | input | 16 | Half-word write data |
| resLo | output | 16 | Result register bits 15:0 |
| resHi | output | 16 | Result register bits 31:16 |

## Verification
The bench sweeps every placement from fully off-scale right to fully off-scale left against both references and both fill modes, because an off-by-one in the reference offset or a clamp at the wrong magnitude would shift the whole sweep by one bit or collapse the end points wrongly. Negative operands in arithmetic mode go after a fill that is taken from the wrong bit or leaks below the operand. A two-step 32-bit shift in each direction catches a merge that overwrites instead of ORing, and a same-cycle shift with half loads catches wrong priority between the two write paths.

// File: rtl/plsh_pkg.sv
package plsh_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // write a placed word into the result register
    logic merge;    // OR with the current result instead of overwrite
    logic wrLo;     // half write of the low 16 bits
    logic wrHi;     // half write of the high 16 bits
  } plsh_ctrl_t;

endpackage

// File: rtl/plsh_ctrl.sv
module plsh_ctrl
  import plsh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic       orMode,
  input  logic       loadLo,
  input  logic       loadHi,
  output plsh_ctrl_t ctrl
);

  // A shift owns the register for its cycle; half loads yield to it.
  always_comb begin
    ctrl.capture = opValid;
    ctrl.merge   = opValid & orMode;
    ctrl.wrLo    = loadLo & ~opValid;
    ctrl.wrHi    = loadHi & ~opValid;
  end

  AST_SHIFT_BEATS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> !(ctrl.wrLo || ctrl.wrHi)); // R10

  AST_LOAD_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && loadLo) |-> ctrl.wrLo); // R9

endmodule

// File: rtl/plsh_placer.sv
module plsh_placer #(
  parameter int IN_W   = 16,
  parameter int CODE_W = 8
) (
  input  logic [IN_W-1:0]   operand,
  input  logic [CODE_W-1:0] code,
  input  logic              refHigh,
  input  logic              arith,
  output logic [2*IN_W-1:0] placed
);

  localparam int OUT_W = 2 * IN_W;
  localparam int EXT_W = OUT_W + IN_W;
  localparam int AMT_W = CODE_W + 2;

  logic [AMT_W-1:0]        amount;
  logic [AMT_W-1:0]        rightAmt;
  logic                    fillBit;
  logic signed [EXT_W-1:0] extended;
  logic [EXT_W-1:0]        wide;

  // Effective placement: signed code plus the reference offset.
  assign amount   = {{2{code[CODE_W-1]}}, code} + (refHigh ? AMT_W'(IN_W) : '0);
  assign rightAmt = AMT_W'(0) - amount;
  assign fillBit  = arith & operand[IN_W-1];
  assign extended = {{OUT_W{fillBit}}, operand};

  // Left placements drop bits past the top; right placements keep the fill.
  always_comb begin
    if (!amount[AMT_W-1]) wide = extended << amount;
    else                  wide = extended >>> rightAmt;
  end

  assign placed = wide[OUT_W-1:0];

endmodule

// File: rtl/plsh_datapath.sv
module plsh_datapath
  import plsh_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  plsh_ctrl_t        ctrl,
  input  logic [IN_W-1:0]   opData,
  input  logic [CODE_W-1:0] shiftCode,
  input  logic              refHigh,
  input  logic              arithMode,
  input  logic [IN_W-1:0]   loadData,
  output logic [2*IN_W-1:0] result
);

  localparam int OUT_W = 2 * IN_W;

  logic [OUT_W-1:0] placed;

  plsh_placer #(.IN_W(IN_W), .CODE_W(CODE_W)) u_placer (
    .operand (opData),
    .code    (shiftCode),
    .refHigh (refHigh),
    .arith   (arithMode),
    .placed  (placed)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
    end else if (ctrl.capture) begin
      result <= ctrl.merge ? (placed | result) : placed;
    end else begin
      if (ctrl.wrLo) result[IN_W-1:0]     <= loadData;
      if (ctrl.wrHi) result[OUT_W-1:IN_W] <= loadData;
    end
  end

  AST_PASS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && !ctrl.merge) |=> result == $past(placed)); // R7

  AST_OR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && ctrl.merge) |=> result == ($past(placed) | $past(result))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.capture && !ctrl.wrLo && !ctrl.wrHi) |=> $stable(result)); // R11

  AST_LOW_HALF_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrLo && !ctrl.wrHi && !ctrl.capture) |=>
      (result[IN_W-1:0] == $past(loadData)) && $stable(result[OUT_W-1:IN_W])); // R9

  AST_HI_ZERO_PLACE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && !ctrl.merge && refHigh && shiftCode == '0) |=>
      (result[OUT_W-1:IN_W] == $past(opData)) && (result[IN_W-1:0] == '0)); // R3

endmodule

// File: rtl/placement_shifter.sv
module placement_shifter
  import plsh_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [IN_W-1:0]   opData,
  input  logic [CODE_W-1:0] shiftCode,
  input  logic              refHigh,
  input  logic              arithMode,
  input  logic              orMode,
  input  logic              loadLo,
  input  logic              loadHi,
  input  logic [IN_W-1:0]   loadData,
  output logic [IN_W-1:0]   resLo,
  output logic [IN_W-1:0]   resHi
);

  localparam int OUT_W = 2 * IN_W;

  plsh_ctrl_t       ctrl;
  logic [OUT_W-1:0] result;

  plsh_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .orMode  (orMode),
    .loadLo  (loadLo),
    .loadHi  (loadHi),
    .ctrl    (ctrl)
  );

  plsh_datapath #(.IN_W(IN_W), .CODE_W(CODE_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .opData    (opData),
    .shiftCode (shiftCode),
    .refHigh   (refHigh),
    .arithMode (arithMode),
    .loadData  (loadData),
    .result    (result)
  );

  assign resLo = result[IN_W-1:0];
  assign resHi = result[OUT_W-1:IN_W];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> (resLo == '0 && resHi == '0)); // R1

endmodule

// File: tb/placement_shifter_bench.sv
module placement_shifter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [15:0] opData = '0;
  logic [7:0]  shiftCode = '0;
  logic        refHigh = 1'b0;
  logic        arithMode = 1'b0;
  logic        orMode = 1'b0;
  logic        loadLo = 1'b0;
  logic        loadHi = 1'b0;
  logic [15:0] loadData = '0;
  logic [15:0] resLo;
  logic [15:0] resHi;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  placement_shifter u_placement_shifter (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opData(opData),
    .shiftCode(shiftCode), .refHigh(refHigh), .arithMode(arithMode),
    .orMode(orMode), .loadLo(loadLo), .loadHi(loadHi), .loadData(loadData),
    .resLo(resLo), .resHi(resHi)
  );

  typedef struct packed {
    logic [15:0] op;
    logic [7:0]  code;
    logic        hi;
    logic        ar;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{16'h8001, 8'h00, 1'b0, 1'b0, 32'h0000_8001},  // R2 logical
    '{16'h8001, 8'h00, 1'b0, 1'b1, 32'hFFFF_8001},  // R2 R5 sign fill
    '{16'h8001, 8'h00, 1'b1, 1'b1, 32'h8001_0000},  // R3
    '{16'h1234, 8'h04, 1'b0, 1'b0, 32'h0001_2340},  // R4 left
    '{16'h8000, 8'hFC, 1'b1, 1'b1, 32'hF800_0000},  // R4 right, R5
    '{16'h00FF, 8'hF8, 1'b0, 1'b0, 32'h0000_0000},  // R4 right off bottom
    '{16'hABCD, 8'h10, 1'b0, 1'b0, 32'hABCD_0000},  // R4
    '{16'h7FFF, 8'h20, 1'b0, 1'b1, 32'h0000_0000},  // R6 off left
    '{16'h8000, 8'hF0, 1'b0, 1'b1, 32'hFFFF_FFFF},  // R6 off right
    '{16'h8000, 8'hF0, 1'b1, 1'b1, 32'hFFFF_8000}   // R3 R4
  };

  function automatic logic [31:0] model(input logic [15:0] op, input int s, input logic ar);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      int j;
      j = i - s;
      if (j >= 0 && j < 16) r[i] = op[j];
      else if (j >= 16)     r[i] = ar & op[15];
      else                  r[i] = 1'b0;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doShift(input logic [15:0] op, input logic [7:0] code,
                         input logic hi, input logic ar, input logic orm);
    @(negedge clk);
    opData = op; shiftCode = code; refHigh = hi; arithMode = ar; orMode = orm;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic doLoad(input logic lo, input logic hi, input logic [15:0] d);
    @(negedge clk);
    loadLo = lo; loadHi = hi; loadData = d;
    @(negedge clk);
    loadLo = 1'b0; loadHi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1 in reset", {resHi, resLo}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {resHi, resLo}, 32'h0);

    // Vector table, PASS mode
    for (int v = 0; v < NVEC; v++) begin
      doShift(VECS[v].op, VECS[v].code, VECS[v].hi, VECS[v].ar, 1'b0);
      check($sformatf("R7 R12 vec %0d", v), {resHi, resLo}, VECS[v].exp);
    end

    // Full sweep of the 49 placements, both references, both fill modes
    for (int s = -16; s <= 32; s++) begin
      for (int h = 0; h < 2; h++) begin
        for (int a = 0; a < 2; a++) begin
          logic [7:0] code;
          code = 8'(s - (h == 1 ? 16 : 0));
          doShift(16'hB3C5, code, h[0], a[0], 1'b0);
          check($sformatf("R4 R5 R6 s=%0d h=%0d a=%0d", s, h, a),
                {resHi, resLo}, model(16'hB3C5, s, a[0]));
        end
      end
    end
    // Far off-scale codes
    doShift(16'hC000, 8'h80, 1'b0, 1'b1, 1'b0);
    check("R6 code -128 arith", {resHi, resLo}, 32'hFFFF_FFFF);
    doShift(16'hFFFF, 8'h7F, 1'b1, 1'b1, 1'b0);
    check("R6 code 127 high", {resHi, resLo}, 32'h0);

    // Double precision left shift by 4
    doShift(16'h1234, 8'h04, 1'b1, 1'b0, 1'b0);
    doShift(16'h5678, 8'h04, 1'b0, 1'b0, 1'b1);
    check("R8 double left", {resHi, resLo}, 32'h1234_5678 << 4);
    // Double precision arithmetic right shift by 4
    doShift(16'h8765, 8'hFC, 1'b1, 1'b1, 1'b0);
    doShift(16'h4321, 8'hFC, 1'b0, 1'b0, 1'b1);
    check("R8 double right", {resHi, resLo}, 32'($signed(32'h8765_4321) >>> 4));

    // Half loads
    doLoad(1'b1, 1'b0, 16'hA5A5);
    check("R9 low half", {resHi, resLo}, 32'hFFFF_A5A5 & {16'hFFFF, 16'hFFFF} & 32'h0000_A5A5 | 32'h0000_0000 | ({32'($signed(32'h8765_4321) >>> 4)} & 32'hFFFF_0000));
    doLoad(1'b0, 1'b1, 16'h5A5A);
    check("R9 high half", {resHi, resLo}, 32'h5A5A_A5A5);
    doLoad(1'b1, 1'b1, 16'h0F0F);
    check("R9 both halves", {resHi, resLo}, 32'h0F0F_0F0F);
    // OR merge with loaded value
    doShift(16'h00F0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R8 or with loaded", {resHi, resLo}, 32'h0F0F_0FFF);

    // Shift and load in the same cycle
    @(negedge clk);
    opData = 16'h0001; shiftCode = 8'h00; refHigh = 1'b0; arithMode = 1'b0; orMode = 1'b0;
    opValid = 1'b1; loadLo = 1'b1; loadHi = 1'b1; loadData = 16'hDEAD;
    @(negedge clk);
    opValid = 1'b0; loadLo = 1'b0; loadHi = 1'b0;
    check("R10 shift wins", {resHi, resLo}, 32'h0000_0001);

    // Idle: wiggle other inputs, register must hold
    held = {resHi, resLo};
    @(negedge clk);
    opData = 16'hFFFF; shiftCode = 8'h05; refHigh = 1'b1; arithMode = 1'b1;
    orMode = 1'b1; loadData = 16'h1111;
    repeat (3) @(negedge clk);
    check("R11 hold", {resHi, resLo}, held);

    // Asynchronous reset clears
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 async clear", {resHi, resLo}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule